// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps a ring of receive descriptors in a small on-chip RAM and hands each finished frame back to the host. Every descriptor is two 32-bit words. The first word carries control, status and length. The second word carries the buffer address, which the engine never alters. The host offers a descriptor by setting its empty flag. When the receive datapath signals the start of a frame, the engine checks the descriptor at the current ring position. At the end of the frame it writes the byte count and the per-frame error flags into that descriptor, clears the empty flag, and moves to the next ring slot.

Interrupt events are collected in a source register that the host clears by writing ones. A frame that arrives when the current descriptor is still owned by the host is dropped whole, and a busy event is raised. The host reaches the descriptor RAM and the two event registers through one register port. Writes to that port take one clock. Reads return data in the same cycle.

Top module: `rxbd_engine`

## Requirements
- R1: After reset, the event source register and the event mask register read 0, `irq` is low, the ring position is descriptor 0, and every descriptor word reads 0.
- R2: Descriptor i is mapped at byte address 0x600 + 8*i: its first (control/status) word is at +0 and its second (buffer address) word is at +4. A host write is stored at the clock edge. A host read returns the stored word in the same cycle.
- R3: A frame is accepted when `frm_start` arrives with `rx_en` high, and the current descriptor's empty flag (bit 15) is set. In the `frm_end` cycle, one RAM write stores the following into the first word: length in bits 31:16, bit 15 = 0, bits 14 and 13 as they were at frame start, bits 12:9 = 0, and `frm_err` in bits 8:0 (bit 8 control frame, 7 miss, 6 overrun, 5 invalid symbol, 4 dribble nibble, 3 too long, 2 short frame, 1 CRC error, 0 late collision). The second word is left unchanged.
- R4: After an accepted frame is written back, the ring position advances by one. It returns to 0 instead if the descriptor's wrap bit (bit 13) was set, or if it was the last descriptor.
- R5: An accepted frame whose descriptor had bit 14 set raises source bit 2 when `frm_err` is zero, and raises source bit 3 otherwise. With bit 14 clear, the frame raises no event.
- R6: A frame that starts with `rx_en` high while the current descriptor's empty flag is clear is dropped. Source bit 4 is set, nothing is written to RAM, the ring position stays where it is, and the `frm_end` of that frame is ignored.
- R7: `rx_en` is looked at only on `frm_start`. A frame that starts with `rx_en` low is ignored entirely, with no write and no event. Dropping `rx_en` during an accepted frame does not stop its write-back.
- R8: The source register sits at address 0x010 and holds bits 4:2. Writing a 1 to a bit clears it. A bit being set in the same cycle as a clear of that bit stays set.
- R9: The mask register sits at address 0x014, is read/write, and holds bits 4:2. `irq` is high exactly when some source bit and its mask bit are both 1.
- R10: When a host write and an engine write-back target the same RAM word in the same cycle, the engine's value is stored.
- R11: A `frm_start` that arrives while a frame is already being received is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable, sampled at frame start |
| frm_start | input | 1 | One-cycle pulse at the start of a frame |
| frm_end | input | 1 | One-cycle pulse at the end of a frame |
| frm_len | input | 16 | Received byte count including CRC, valid with frm_end |
| frm_err | input | 9 | Per-frame error flags, valid with frm_end |
| host_addr | input | 11 | Host byte address |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| irq | output | 1 | Masked interrupt request |

## Verification
Every result lands exactly one clock edge after its cause. A busy event shows in the source register and on `irq` after the edge that sampled `frm_start`. A write-back, its event and the ring advance all show after the edge that sampled `frm_end`. A host write becomes visible after its own edge, while a read needs no edge at all. The bench drives every input on the falling edge and holds it for exactly one rising edge. It reads the results back through the host port on the next falling edge, so each check looks at the first cycle in which the new value is due. Cases that depend on two things happening in the same cycle (a host write colliding with a write-back, a clear coinciding with a set) are driven on the same falling edge.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

    // Control/status word bit positions (host software decodes these)
    localparam int BD_EMPTY = 15;
    localparam int BD_IRQ   = 14;
    localparam int BD_WRAP  = 13;
    localparam int LEN_W    = 16;
    localparam int ERR_W    = 9;

    // Event source bit positions as seen by the host
    localparam int EV_LO    = 2;  // frame received cleanly
    localparam int EV_W     = 3;  // bits 4:2 -> ok, error, busy

    // Host map
    localparam int BD_BASE  = 'h600;
    localparam int SRC_ADR  = 'h010;
    localparam int MASK_ADR = 'h014;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_FILL = 2'd1,
        RS_SKIP = 2'd2
    } ring_st_e;

endpackage

// File: rtl/rxbd_ring.sv
module rxbd_ring
    import rxbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             frm_start,
    input  logic             frm_end,
    input  logic [LEN_W-1:0] frm_len,
    input  logic [ERR_W-1:0] frm_err,
    input  logic [2:0]       cur_ctrl,   // {empty, irq request, wrap} of current slot
    output logic [IDX_W-1:0] cur_idx,
    output logic             wb_vld,
    output logic [31:0]      wb_word,
    output logic             ev_ok,
    output logic             ev_err,
    output logic             ev_busy
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1);

    typedef struct packed {
        ring_st_e         st;
        logic [IDX_W-1:0] idx;
        logic             irq_req;
        logic             wrap;
    } ring_s;

    ring_s r_d, r_q;

    always_comb begin
        r_d     = r_q;
        wb_vld  = 1'b0;
        ev_ok   = 1'b0;
        ev_err  = 1'b0;
        ev_busy = 1'b0;
        case (r_q.st)
            RS_IDLE: begin
                if (frm_start && rx_en) begin
                    if (cur_ctrl[2]) begin
                        r_d.st      = RS_FILL;
                        r_d.irq_req = cur_ctrl[1];
                        r_d.wrap    = cur_ctrl[0];
                    end else begin
                        r_d.st  = RS_SKIP;
                        ev_busy = 1'b1;
                    end
                end
            end
            RS_FILL: begin
                if (frm_end) begin
                    wb_vld  = 1'b1;
                    ev_ok   = r_q.irq_req && (frm_err == '0);
                    ev_err  = r_q.irq_req && (frm_err != '0);
                    r_d.st  = RS_IDLE;
                    r_d.idx = (r_q.wrap || r_q.idx == LAST) ? '0 : r_q.idx + 1'b1;
                end
            end
            RS_SKIP: begin
                if (frm_end) r_d.st = RS_IDLE;
            end
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: RS_IDLE, idx: '0, irq_req: 1'b0, wrap: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cur_idx = r_q.idx;
    assign wb_word = {frm_len, 1'b0, r_q.irq_req, r_q.wrap, 4'b0000, frm_err};

endmodule

// File: rtl/rxbd_store.sv
module rxbd_store #(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int WIDX_W  = IDX_W + 1,
    localparam int WORDS   = 2 * NUM_DESC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [WIDX_W-1:0] host_widx,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rword,
    input  logic              eng_we,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [31:0]       eng_wdata,
    output logic [2:0]        cur_ctrl
);

    logic [31:0] mem_d [WORDS];
    logic [31:0] mem_q [WORDS];

    logic [WIDX_W-1:0] eng_widx;
    assign eng_widx = {cur_idx, 1'b0};

    always_comb begin
        for (int i = 0; i < WORDS; i++) mem_d[i] = mem_q[i];
        if (host_we) mem_d[host_widx] = host_wdata;
        // engine write-back is applied last so it wins a collision
        if (eng_we)  mem_d[eng_widx]  = eng_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

    logic [31:0] cur_word;
    assign cur_word   = mem_q[eng_widx];
    assign cur_ctrl   = cur_word[15:13];
    assign host_rword = mem_q[host_widx];

endmodule

// File: rtl/rxbd_irq.sv
module rxbd_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_ok,
    input  logic       ev_err,
    input  logic       ev_busy,
    input  logic       clr_we,
    input  logic       mask_we,
    input  logic [2:0] wbits,
    output logic [2:0] src_bits,
    output logic [2:0] mask_bits,
    output logic       irq
);

    typedef struct packed {
        logic [2:0] src;
        logic [2:0] mask;
    } evt_s;

    evt_s e_d, e_q;

    always_comb begin
        e_d = e_q;
        if (clr_we) e_d.src = e_q.src & ~wbits;
        // newly arriving events override a coincident clear
        e_d.src = e_d.src | {ev_busy, ev_err, ev_ok};
        if (mask_we) e_d.mask = wbits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else begin
            e_q <= e_d;
        end
    end

    assign src_bits  = e_q.src;
    assign mask_bits = e_q.mask;
    assign irq       = |(e_q.src & e_q.mask);

endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
    import rxbd_pkg::*;
#(
    parameter int NUM_DESC = 8,
    parameter int ADDR_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              frm_start,
    input  logic              frm_end,
    input  logic [15:0]       frm_len,
    input  logic [8:0]        frm_err,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_we,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              irq
);

    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1;
    localparam int WIDX_W  = IDX_W + 1;
    localparam int BD_SPAN = 8 * NUM_DESC;

    localparam logic [ADDR_W-1:0] BD_BASE_A = ADDR_W'(BD_BASE);
    localparam logic [ADDR_W-1:0] BD_SPAN_A = ADDR_W'(BD_SPAN);
    localparam logic [ADDR_W-1:0] SRC_A     = ADDR_W'(SRC_ADR);
    localparam logic [ADDR_W-1:0] MASK_A    = ADDR_W'(MASK_ADR);

    // Host address decode
    logic [ADDR_W-1:0] bd_off;
    logic              in_bd, sel_src, sel_mask;
    logic [WIDX_W-1:0] host_widx;

    assign bd_off    = host_addr - BD_BASE_A;
    assign in_bd     = (host_addr >= BD_BASE_A) && (bd_off < BD_SPAN_A);
    assign sel_src   = (host_addr == SRC_A);
    assign sel_mask  = (host_addr == MASK_A);
    assign host_widx = bd_off[WIDX_W+1:2];

    logic [IDX_W-1:0] cur_idx;
    logic [2:0]       cur_ctrl;
    logic             wb_vld;
    logic [31:0]      wb_word;
    logic             ev_ok, ev_err, ev_busy;
    logic [31:0]      bd_rword;
    logic [2:0]       src_bits, mask_bits;

    rxbd_ring #(.NUM_DESC(NUM_DESC)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .frm_start (frm_start),
        .frm_end   (frm_end),
        .frm_len   (frm_len),
        .frm_err   (frm_err),
        .cur_ctrl  (cur_ctrl),
        .cur_idx   (cur_idx),
        .wb_vld    (wb_vld),
        .wb_word   (wb_word),
        .ev_ok     (ev_ok),
        .ev_err    (ev_err),
        .ev_busy   (ev_busy)
    );

    rxbd_store #(.NUM_DESC(NUM_DESC)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we && in_bd),
        .host_widx  (host_widx),
        .host_wdata (host_wdata),
        .host_rword (bd_rword),
        .eng_we     (wb_vld),
        .cur_idx    (cur_idx),
        .eng_wdata  (wb_word),
        .cur_ctrl   (cur_ctrl)
    );

    rxbd_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_ok     (ev_ok),
        .ev_err    (ev_err),
        .ev_busy   (ev_busy),
        .clr_we    (host_we && sel_src),
        .mask_we   (host_we && sel_mask),
        .wbits     (host_wdata[EV_LO+EV_W-1:EV_LO]),
        .src_bits  (src_bits),
        .mask_bits (mask_bits),
        .irq       (irq)
    );

    always_comb begin
        host_rdata = '0;
        if (in_bd)         host_rdata = bd_rword;
        else if (sel_src)  host_rdata[EV_LO+EV_W-1:EV_LO] = src_bits;
        else if (sel_mask) host_rdata[EV_LO+EV_W-1:EV_LO] = mask_bits;
    end

endmodule

// File: rtl/rxbd_engine_chk.sv
module rxbd_engine_chk #(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_en,
    input logic             frm_start,
    input logic [IDX_W-1:0] cur_idx,
    input logic             wb_vld,
    input logic [31:0]      wb_word,
    input logic             ev_ok,
    input logic             ev_err,
    input logic             ev_busy,
    input logic [2:0]       src_bits
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1);

    // R4: ring position never leaves the ring
    a_r4_idx_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_idx) < NUM_DESC);

    // R4: plain step after a write-back without wrap
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && !wb_word[13] && cur_idx != LAST) |=> cur_idx == IDX_W'($past(cur_idx) + 1'b1));

    // R4: wrap bit returns the ring to slot 0
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && wb_word[13]) |=> cur_idx == '0);

    // R6: dropped frame keeps the ring position and flags busy
    a_r6_busy_holds_idx: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy |=> $stable(cur_idx));

    a_r6_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy |=> src_bits[2]);

    // R5: frame events reach the source register
    a_r5_ok_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ok |=> src_bits[0]);

    a_r5_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> src_bits[1]);

    // R7: a disabled receiver never reports busy
    a_r7_off_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_start && !rx_en) |-> !ev_busy);

endmodule

bind rxbd_engine rxbd_engine_chk #(.NUM_DESC(NUM_DESC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .frm_start (frm_start),
    .cur_idx   (cur_idx),
    .wb_vld    (wb_vld),
    .wb_word   (wb_word),
    .ev_ok     (ev_ok),
    .ev_err    (ev_err),
    .ev_busy   (ev_busy),
    .src_bits  (src_bits)
);

// File: tb/tb_rxbd_engine.sv
`timescale 1ns/1ps
module tb_rxbd_engine;

    localparam int ND = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        frm_start = 1'b0;
    logic        frm_end = 1'b0;
    logic [15:0] frm_len = '0;
    logic [8:0]  frm_err = '0;
    logic [10:0] host_addr = '0;
    logic        host_we = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rxbd_engine #(.NUM_DESC(ND)) dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
        .frm_start(frm_start), .frm_end(frm_end),
        .frm_len(frm_len), .frm_err(frm_err),
        .host_addr(host_addr), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        en;
        logic [15:0] len;
        logic [8:0]  err;
        logic [10:0] paddr;
        logic [31:0] pval;
        logic [4:0]  src;
        logic [3:0]  req;
    } vec_t;

    // Ring starts with every slot empty + irq request, slot 3 carries wrap.
    localparam vec_t VECS [6] = '{
        '{1'b1, 16'h0040, 9'h000, 11'h600, 32'h0040_4000, 5'h04, 4'd3}, // R3 clean frame into slot 0
        '{1'b1, 16'h05EE, 9'h002, 11'h608, 32'h05EE_4002, 5'h08, 4'd5}, // R5 CRC error -> error event
        '{1'b0, 16'h0064, 9'h000, 11'h610, 32'h0000_C000, 5'h00, 4'd7}, // R7 disabled, slot 2 untouched
        '{1'b1, 16'h0080, 9'h100, 11'h610, 32'h0080_4100, 5'h08, 4'd5}, // R5 control-frame flag
        '{1'b1, 16'h0044, 9'h000, 11'h618, 32'h0044_6000, 5'h04, 4'd4}, // R4 wrap bit kept, ring returns to 0
        '{1'b1, 16'h0050, 9'h000, 11'h600, 32'h0040_4000, 5'h10, 4'd6}  // R6 slot 0 still full -> busy
    };

    task automatic chk(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL R%0d: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic hwrite(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input logic [10:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic fstart(input logic en);
        @(negedge clk);
        rx_en = en; frm_start = 1'b1;
        @(negedge clk);
        frm_start = 1'b0;
    endtask

    // Optional host write in the same cycle as the frame end
    task automatic fend(input logic [15:0] len, input logic [8:0] err,
                        input logic hw, input logic [10:0] ha, input logic [31:0] hd);
        @(negedge clk);
        frm_end = 1'b1; frm_len = len; frm_err = err;
        host_we = hw; host_addr = ha; host_wdata = hd;
        @(negedge clk);
        frm_end = 1'b0; host_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        hread(11'h010, rd); chk(1, rd, 32'h0);
        hread(11'h014, rd); chk(1, rd, 32'h0);
        chk(1, {31'b0, irq}, 32'h0);
        hread(11'h600, rd); chk(1, rd, 32'h0);
        hread(11'h61C, rd); chk(1, rd, 32'h0);

        // R2: arm the ring through the host port and read back
        for (int i = 0; i < ND; i++) begin
            hwrite(11'(11'h600 + 8*i), (i == ND-1) ? 32'h0000_E000 : 32'h0000_C000);
            hwrite(11'(11'h604 + 8*i), 32'h1000_0000 + 32'(i * 'h100));
        end
        hread(11'h60C, rd); chk(2, rd, 32'h1000_0100);
        hread(11'h618, rd); chk(2, rd, 32'h0000_E000);
        hwrite(11'h014, 32'h0000_001C);
        hread(11'h014, rd); chk(9, rd, 32'h0000_001C);

        for (int v = 0; v < 6; v++) begin
            fstart(VECS[v].en);
            repeat (2) @(negedge clk);
            fend(VECS[v].len, VECS[v].err, 1'b0, 11'h0, 32'h0);
            hread(VECS[v].paddr, rd); chk(int'(VECS[v].req), rd, VECS[v].pval);
            hread(11'h010, rd);       chk(int'(VECS[v].req), rd, {27'b0, VECS[v].src});
            chk(9, {31'b0, irq}, {31'b0, VECS[v].src != 5'h0});
            hwrite(11'h010, 32'h0000_001C);
            hread(11'h010, rd); chk(8, rd, 32'h0);
        end
        // R3: buffer address word untouched by the write-back
        hread(11'h604, rd); chk(3, rd, 32'h1000_0000);

        // R6 recheck at same slot, R5 no event without irq request
        hwrite(11'h600, 32'h0000_8000);
        fstart(1'b1);
        fend(16'h0050, 9'h000, 1'b0, 11'h0, 32'h0);
        hread(11'h600, rd); chk(6, rd, 32'h0050_0000);
        hread(11'h010, rd); chk(5, rd, 32'h0);

        // R7: enable dropped mid-frame, write-back still lands in slot 1
        hwrite(11'h608, 32'h0000_C000);
        fstart(1'b1);
        rx_en = 1'b0;
        fend(16'h0060, 9'h000, 1'b0, 11'h0, 32'h0);
        hread(11'h608, rd); chk(7, rd, 32'h0060_4000);
        hread(11'h010, rd); chk(7, rd, 32'h0000_0004);
        hwrite(11'h010, 32'h0000_001C);

        // R11: second start inside a frame is ignored
        hwrite(11'h610, 32'h0000_C000);
        hwrite(11'h618, 32'h0000_E000);
        fstart(1'b1);
        fstart(1'b1);
        fend(16'h0070, 9'h010, 1'b0, 11'h0, 32'h0);
        hread(11'h610, rd); chk(11, rd, 32'h0070_4010);
        hread(11'h618, rd); chk(11, rd, 32'h0000_E000);
        hwrite(11'h010, 32'h0000_001C);

        // R10: host write to the same word as the write-back loses
        fstart(1'b1);
        fend(16'h0048, 9'h000, 1'b1, 11'h618, 32'h1234_5678);
        hread(11'h618, rd); chk(10, rd, 32'h0048_6000);
        hwrite(11'h010, 32'h0000_001C);
        hread(11'h010, rd); chk(8, rd, 32'h0);

        // R8: event set in the same cycle as a clear survives; R4 ring wrapped to 0
        hwrite(11'h600, 32'h0000_C000);
        fstart(1'b1);
        fend(16'h0052, 9'h004, 1'b1, 11'h010, 32'h0000_001C);
        hread(11'h600, rd); chk(4, rd, 32'h0052_4004);
        hread(11'h010, rd); chk(8, rd, 32'h0000_0008);

        // R9: masking
        hwrite(11'h014, 32'h0000_0000);
        chk(9, {31'b0, irq}, 32'h0);
        hwrite(11'h014, 32'h0000_0004);
        chk(9, {31'b0, irq}, 32'h0);
        hwrite(11'h014, 32'h0000_0008);
        chk(9, {31'b0, irq}, 32'h1);
        hread(11'h014, rd); chk(9, rd, 32'h0000_0008);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule